// File: doc/BRIEF.md
# SDRAM Read Burst Output Pipeline

This block is the device-side read path of a synchronous DRAM. It watches a decoded command stream, and when it captures a READ it walks the burst columns, fetches each word from a small internal word array, and presents the words on a data output with an output-enable. The output-enable is the control for the chip's tri-state data pad. The first word appears a run-time selectable CAS latency after the command. The remaining words follow on consecutive rising edges in sequential or interleaved order within the aligned burst block. The enable drops by itself when the burst runs out.

A per-cycle data mask blanks individual beats with a fixed two-cycle delay, and the masked beat is still consumed. A READ that arrives while a burst is running cuts that burst short. The new burst's data follows the old data with no idle cycle when the latency is unchanged. All other commands pass through without effect. The word array holds a fixed pattern, so that the read path can be exercised on its own.

Top module: `sdr_rd_burst`

## Requirements
- R1: While rst_ni is low and after its release with no READ, dq_oe_o is 0 and dq_o is all zeros.
- R2: A READ (cmd_i = 3'd2) captured at rising edge E with lat3_i = 0 makes the first word valid from edge E+2 on. That word is the one at the starting column col_i, and the word stored at column c is ((c*257) XOR 16'h3C5A) truncated to 16 bits.
- R3: With lat3_i = 1 at the READ, the first word is valid from edge E+3 on.
- R4: Each later beat is valid one edge after the one before. The burst length comes from bl_i at the READ: 2'b00 gives 1 beat, 2'b01 gives 2, 2'b10 gives 4 and 2'b11 gives 8.
- R5: With ilv_i = 0 at the READ, beat k reads the column whose upper bits match the start column and whose low log2(BL) bits are (start + k) mod BL.
- R6: With ilv_i = 1 at the READ, the low log2(BL) bits of beat k are start XOR k, and the upper bits are kept.
- R7: On the edge after the last beat, dq_oe_o returns to 0 when no new READ is pending.
- R8: dqm_i = 1 sampled at edge M forces dq_oe_o to 0 for the beat presented from edge M+2. The burst still advances past that beat.
- R9: A READ captured during a burst ends the old burst's remaining beats. With the same latency, the new data starts at its own latency with no cycle of dq_oe_o = 0 between the two bursts.
- R10: Every other cmd_i code (NOP 0, activate 1, write 3, precharge 4, others 5 to 7), and any col_i, bl_i or ilv_i value outside a READ, leaves a running burst and its outputs unchanged.
- R11: Whenever dq_oe_o is 0, dq_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 3 | Decoded command code, READ = 3'd2 |
| col_i | input | COL_W (6) | Starting column, sampled with READ |
| bl_i | input | 2 | Burst length code, sampled with READ |
| ilv_i | input | 1 | Burst order: 0 sequential, 1 interleaved |
| lat3_i | input | 1 | CAS latency select: 0 gives 2 cycles, 1 gives 3 |
| dqm_i | input | 1 | Data mask, acts two edges after capture |
| dq_o | output | DATA_W (16) | Read data |
| dq_oe_o | output | 1 | Output-enable for the data pad |

## Verification
The assertions check on every cycle that the enable rises at the selected latency after each READ unless a mask was captured three samples back. They also check that a mask always blanks its beat, that the data is zero whenever the pad is released, and that the pad is always released a fixed distance after the last READ. Only the directed scenarios can show the column order for each burst length and order mode, the stored word contents, the exact edge on which a burst ends, the gapless handover of a truncating READ, and that non-READ commands leave a burst alone.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_ACT   = 3'd1,
    CMD_READ  = 3'd2,
    CMD_WRITE = 3'd3,
    CMD_PRE   = 3'd4,
    CMD_REF   = 3'd5,
    CMD_MODE  = 3'd6,
    CMD_RSVD  = 3'd7
  } cmd_e;

  localparam int unsigned CMD_W     = 3;
  localparam int unsigned BL_CODE_W = 2;
  // longest burst is 2**BLG_MAX beats
  localparam int unsigned BLG_MAX   = (1 << BL_CODE_W) - 1;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sdr_rd_seq.sv
module sdr_rd_seq
  import sdr_rd_pkg::*;
#(
  parameter int unsigned COL_W = 6,
  parameter int unsigned LS_W  = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 rd_i,
  input  logic [COL_W-1:0]     col_i,
  input  logic [BL_CODE_W-1:0] bl_i,
  input  logic                 ilv_i,
  input  logic [LS_W-1:0]      lat_sel_i,
  output logic                 beat_v_o,
  output logic [COL_W-1:0]     beat_col_o,
  output logic [LS_W-1:0]      beat_lat_o
);

  logic                 act_q;
  logic [COL_W-1:0]     start_q;
  logic [BLG_MAX-1:0]   k_q;
  logic [BL_CODE_W-1:0] lg_q;
  logic                 ilv_q;
  logic [LS_W-1:0]      lat_q;

  logic [BLG_MAX-1:0]   blk_m;
  logic [BLG_MAX-1:0]   lo;
  logic [BLG_MAX-1:0]   off;

  // mask of the in-block column bits; also equals the last beat index
  always_comb begin
    for (int i = 0; i < BLG_MAX; i++) blk_m[i] = (i < int'(lg_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      start_q <= '0;
      k_q     <= '0;
      lg_q    <= '0;
      ilv_q   <= 1'b0;
      lat_q   <= '0;
    end else if (rd_i) begin
      act_q   <= 1'b1;
      start_q <= col_i;
      k_q     <= '0;
      lg_q    <= bl_i;
      ilv_q   <= ilv_i;
      lat_q   <= lat_sel_i;
    end else if (act_q) begin
      if (k_q == blk_m) act_q <= 1'b0;
      else              k_q   <= k_q + 1'b1;
    end
  end

  always_comb begin
    lo  = start_q[BLG_MAX-1:0];
    off = ilv_q ? (lo ^ k_q) : (lo + k_q);
  end

  assign beat_v_o   = act_q;
  assign beat_col_o = {start_q[COL_W-1:BLG_MAX], (lo & ~blk_m) | (off & blk_m)};
  assign beat_lat_o = lat_q;

endmodule

// File: rtl/sdr_rd_lat_pipe.sv
module sdr_rd_lat_pipe #(
  parameter int unsigned COL_W = 6,
  parameter int unsigned NSTG  = 2,
  parameter int unsigned LS_W  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_v_i,
  input  logic [COL_W-1:0] beat_col_i,
  input  logic [LS_W-1:0]  beat_lat_i,
  output logic             sel_v_o,
  output logic [COL_W-1:0] sel_col_o
);

  logic [NSTG-1:0] v_q;
  logic [COL_W-1:0] c_q [NSTG];
  logic [LS_W-1:0]  s_q [NSTG];

  for (genvar j = 0; j < NSTG; j++) begin : g_stg
    if (j == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[j] <= 1'b0;
          c_q[j] <= '0;
          s_q[j] <= '0;
        end else begin
          v_q[j] <= beat_v_i;
          c_q[j] <= beat_col_i;
          s_q[j] <= beat_lat_i;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q[j] <= 1'b0;
          c_q[j] <= '0;
          s_q[j] <= '0;
        end else begin
          v_q[j] <= v_q[j-1];
          c_q[j] <= c_q[j-1];
          s_q[j] <= s_q[j-1];
        end
      end
    end
  end

  // a beat leaves at the stage matching its own latency; deeper stage wins
  always_comb begin
    sel_v_o   = 1'b0;
    sel_col_o = '0;
    for (int j = 0; j < int'(NSTG); j++) begin
      if (v_q[j] && (s_q[j] == LS_W'(j))) begin
        sel_v_o   = 1'b1;
        sel_col_o = c_q[j];
      end
    end
  end

endmodule

// File: rtl/sdr_rd_array.sv
module sdr_rd_array #(
  parameter int unsigned            COL_W  = 6,
  parameter int unsigned            DATA_W = 16,
  parameter logic [DATA_W-1:0]      SEED   = 16'h3C5A
) (
  input  logic [COL_W-1:0]  rd_col_i,
  output logic [DATA_W-1:0] rd_data_o
);

  localparam int unsigned DEPTH = 1 << COL_W;

  logic [DATA_W-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign rom[i] = DATA_W'(i * 257) ^ SEED;
  end

  assign rd_data_o = rom[rd_col_i];

endmodule

// File: rtl/sdr_rd_out.sv
module sdr_rd_out #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned MASK_DLY = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_v_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              dqm_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);

  logic [MASK_DLY-1:0] mq_q;
  logic                drive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mq_q <= '0;
    else         mq_q <= {mq_q[MASK_DLY-2:0], dqm_i};
  end

  assign drive = sel_v_i & ~mq_q[MASK_DLY-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_oe_o <= 1'b0;
      dq_o    <= '0;
    end else begin
      dq_oe_o <= drive;
      dq_o    <= drive ? data_i : '0;
    end
  end

endmodule

// File: rtl/sdr_rd_burst.sv
module sdr_rd_burst
  import sdr_rd_pkg::*;
#(
  parameter int unsigned COL_W   = 6,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned LAT_MIN = 2,
  parameter int unsigned LAT_MAX = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CMD_W-1:0]     cmd_i,
  input  logic [COL_W-1:0]     col_i,
  input  logic [BL_CODE_W-1:0] bl_i,
  input  logic                 ilv_i,
  input  logic                 lat3_i,
  input  logic                 dqm_i,
  output logic [DATA_W-1:0]    dq_o,
  output logic                 dq_oe_o
);

  localparam int unsigned NSTG = LAT_MAX - LAT_MIN + 1;
  localparam int unsigned LS_W = sel_width(NSTG);

  logic              rd;
  logic              beat_v;
  logic [COL_W-1:0]  beat_col;
  logic [LS_W-1:0]   beat_lat;
  logic              sel_v;
  logic [COL_W-1:0]  sel_col;
  logic [DATA_W-1:0] rd_data;

  assign rd = (cmd_i == CMD_READ);

  sdr_rd_seq #(.COL_W(COL_W), .LS_W(LS_W)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_i       (rd),
    .col_i      (col_i),
    .bl_i       (bl_i),
    .ilv_i      (ilv_i),
    .lat_sel_i  (LS_W'(lat3_i)),
    .beat_v_o   (beat_v),
    .beat_col_o (beat_col),
    .beat_lat_o (beat_lat)
  );

  sdr_rd_lat_pipe #(.COL_W(COL_W), .NSTG(NSTG), .LS_W(LS_W)) i_pipe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_v_i   (beat_v),
    .beat_col_i (beat_col),
    .beat_lat_i (beat_lat),
    .sel_v_o    (sel_v),
    .sel_col_o  (sel_col)
  );

  sdr_rd_array #(.COL_W(COL_W), .DATA_W(DATA_W)) i_array (
    .rd_col_i  (sel_col),
    .rd_data_o (rd_data)
  );

  sdr_rd_out #(.DATA_W(DATA_W), .MASK_DLY(2)) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_v_i (sel_v),
    .data_i  (rd_data),
    .dqm_i   (dqm_i),
    .dq_o    (dq_o),
    .dq_oe_o (dq_oe_o)
  );

endmodule

// File: rtl/sdr_rd_burst_chk.sv
module sdr_rd_burst_chk
  import sdr_rd_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CMD_W-1:0]  cmd_i,
  input logic              lat3_i,
  input logic              dqm_i,
  input logic [DATA_W-1:0] dq_o,
  input logic              dq_oe_o
);

  logic [1:0] warm_q;
  logic [3:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warm_q <= '0;
      idle_q <= 4'd15;
    end else begin
      if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
      if (cmd_i == CMD_READ)   idle_q <= '0;
      else if (idle_q != 4'd15) idle_q <= idle_q + 4'd1;
    end
  end

  assert_hiz_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> (dq_o == '0));

  assert_mask_blank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && $past(dqm_i, 3)) |-> !dq_oe_o);

  assert_lat2_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_READ && !lat3_i) |-> ##3 (dq_oe_o || $past(dqm_i, 3)));

  assert_lat3_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_READ && lat3_i) |-> ##4 (dq_oe_o || $past(dqm_i, 3)));

  assert_burst_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_q >= 4'd12) |-> !dq_oe_o);

endmodule

bind sdr_rd_burst sdr_rd_burst_chk #(.DATA_W(DATA_W)) i_sdr_rd_burst_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cmd_i   (cmd_i),
  .lat3_i  (lat3_i),
  .dqm_i   (dqm_i),
  .dq_o    (dq_o),
  .dq_oe_o (dq_oe_o)
);

// File: tb/test_sdr_rd_burst.sv
module test_sdr_rd_burst;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int COL_W  = 6;
  localparam int DATA_W = 16;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic [2:0]        cmd_i;
  logic [COL_W-1:0]  col_i;
  logic [1:0]        bl_i;
  logic              ilv_i;
  logic              lat3_i;
  logic              dqm_i;
  logic [DATA_W-1:0] dq_o;
  logic              dq_oe_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk_i = ~clk_i;

  sdr_rd_burst #(.COL_W(COL_W), .DATA_W(DATA_W)) i_sdr_rd_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cmd_i   (cmd_i),
    .col_i   (col_i),
    .bl_i    (bl_i),
    .ilv_i   (ilv_i),
    .lat3_i  (lat3_i),
    .dqm_i   (dqm_i),
    .dq_o    (dq_o),
    .dq_oe_o (dq_oe_o)
  );

  function automatic logic [15:0] word_at(input int c);
    return 16'((c * 257) ^ 16'h3C5A);
  endfunction

  function automatic int col_of(input int start, input int k, input int code, input bit ilv);
    int n, lo, base;
    n    = 1 << code;
    lo   = start % n;
    base = start - lo;
    return ilv ? base + (lo ^ k) : base + ((lo + k) % n);
  endfunction

  task automatic check(input string tag, input int t, input bit exp_oe, input logic [15:0] exp_dq);
    n_chk++;
    if (dq_oe_o !== exp_oe || dq_o !== exp_dq) begin
      n_fail++;
      $display("FAIL %s step %0d: oe=%0b dq=%h expected oe=%0b dq=%h",
               tag, t, dq_oe_o, dq_o, exp_oe, exp_dq);
    end
  endtask

  // READ A at step 0; optional READ B at step j; dqm at step m; foreign commands at steps 1..4
  task automatic play(input string tag, input int col_a, input bit l3, input int bl_a,
                      input bit ilv, input int j, input int col_b, input int bl_b,
                      input int m, input bit others);
    int la, na, nb, t_end, ka, kb;
    bit ev, msk;
    int ec;
    la = l3 ? 3 : 2;
    na = 1 << bl_a;
    nb = 1 << bl_b;
    t_end = la + 1 + na;
    if (j >= 0 && j + la + 1 + nb > t_end) t_end = j + la + 1 + nb;
    t_end += 2;
    cmd_i = 3'd2; col_i = COL_W'(col_a); bl_i = 2'(bl_a); ilv_i = ilv; lat3_i = l3;
    dqm_i = (m == 0);
    for (int t = 1; t <= t_end; t++) begin
      @(negedge clk_i);
      ev = 1'b0; ec = 0;
      ka = t - (la + 1);
      if (ka >= 0 && ka < na && (j < 0 || ka < j)) begin
        ev = 1'b1; ec = col_of(col_a, ka, bl_a, ilv);
      end
      if (j >= 0) begin
        kb = t - j - (la + 1);
        if (kb >= 0 && kb < nb) begin
          ev = 1'b1; ec = col_of(col_b, kb, bl_b, ilv);
        end
      end
      msk = (m >= 0 && t - 3 == m);
      check(tag, t, ev && !msk, (ev && !msk) ? word_at(ec) : 16'h0);
      // next step inputs; non-READ steps carry junk fields
      col_i = COL_W'(t * 7 + 3); bl_i = 2'(t); ilv_i = ~ilv;
      cmd_i = 3'd0;
      if (others) begin
        case (t)
          1: cmd_i = 3'd1;
          2: cmd_i = 3'd3;
          3: cmd_i = 3'd4;
          4: cmd_i = 3'd7;
          default: cmd_i = 3'd0;
        endcase
      end
      if (t == j) begin
        cmd_i = 3'd2; col_i = COL_W'(col_b); bl_i = 2'(bl_b); ilv_i = ilv;
      end
      dqm_i = (t == m);
    end
    cmd_i = 3'd0; dqm_i = 1'b0; ilv_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic test_reset;
    rst_ni = 1'b0; cmd_i = 3'd0; col_i = '0; bl_i = '0; ilv_i = 0; lat3_i = 0; dqm_i = 0;
    repeat (3) @(negedge clk_i);
    check("R1/R11 in reset", 0, 1'b0, 16'h0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 after release", 0, 1'b0, 16'h0);
  endtask

  task automatic test_lat2;
    play("R2/R4/R5/R7", 5, 1'b0, 2, 1'b0, -1, 0, 0, -1, 1'b0);
  endtask

  task automatic test_lat3;
    play("R3/R4/R5/R7", 'h2D, 1'b1, 3, 1'b0, -1, 0, 0, -1, 1'b0);
  endtask

  task automatic test_interleave;
    play("R6 lat2 bl8", 'h1B, 1'b0, 3, 1'b1, -1, 0, 0, -1, 1'b0);
    play("R6 lat3 bl4", 'h32, 1'b1, 2, 1'b1, -1, 0, 0, -1, 1'b0);
  endtask

  task automatic test_short;
    play("R4/R7 bl1", 9, 1'b0, 0, 1'b0, -1, 0, 0, -1, 1'b0);
    play("R4/R5 bl2 wrap", 'h3F, 1'b1, 1, 1'b0, -1, 0, 0, -1, 1'b0);
  endtask

  task automatic test_mask;
    play("R8/R11 lat2", 5, 1'b0, 2, 1'b0, -1, 0, 0, 1, 1'b0);
    play("R8/R11 lat3", 'h10, 1'b1, 3, 1'b0, -1, 0, 0, 3, 1'b0);
  endtask

  task automatic test_trunc;
    play("R9 lat2", 4, 1'b0, 3, 1'b0, 2, 'h31, 2, -1, 1'b0);
    play("R9 lat3", 'h21, 1'b1, 3, 1'b0, 5, 'h12, 1, -1, 1'b0);
  endtask

  task automatic test_others;
    play("R10", 'h20, 1'b0, 3, 1'b0, -1, 0, 0, -1, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    test_reset();
    test_lat2();
    test_lat3();
    test_interleave();
    test_short();
    test_mask();
    test_trunc();
    test_others();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule